// File: doc/BRIEF.md
# Adaptive Pruning Survivor Path Unit

This block is the add-compare-select and path-management core of a soft-output Viterbi decoder for a rate one-half code with constraint length 4. It does not track a survivor for every trellis state. It keeps a short list of live paths, at most one per slot. Each slot holds a 12-bit metric, where larger means more likely, a 3-bit encoder state and a 16-bit history of decisions. On each trellis step, every live path is extended by both possible input bits. Each extension adds one of four branch metrics supplied on `bm_in`. Extensions that fall too far below the best are dropped. The best survivors are then kept, up to a runtime limit.

The limit and the threshold are written through a small configuration port. The written values only take effect at a periodic reconfiguration boundary, set by the `RECFG_STEPS` parameter (250,000 steps by default). A controller watching the signal quality can therefore widen the search on a weak channel and narrow it on a strong one. The unit takes one step per accepted `bm_valid` while `ready` is high. It spends one cycle per kept path ranking the survivors, then pulses `step_done`. At that point it reports the decoded bit, the end state of the best path and the number of live paths.

Top module: `sova_path_unit`

## Requirements
- R1: Live path p in slot i with state s and metric pm yields two candidates, with index 2*i+u for input bit u. Each candidate has next state {s[1:0],u} and output symbol {u, u^s[2]^s[0]}. Its metric is pm plus the 8-bit branch metric in `bm_in[8*sym +: 8]`.
- R2: A candidate is dropped in the step in which best_candidate_metric minus its metric exceeds the active threshold. Candidates equal to the best always survive, so with a threshold of 0 exact ties are kept.
- R3: Of the candidates that pass the threshold, the unit keeps the ones with the largest metric and stores them in descending order from slot 0. Equal metrics are ordered by lower candidate index, so slot 0 holds the best path.
- R4: The live count after a step never exceeds the active limit M. A written limit of 0 is taken as 1, and a value above 8 is taken as 8.
- R5: Each kept metric is renormalised to 4095 - (best - metric), so the best path always sits at 4095 and metrics never overflow over any number of steps.
- R6: Each kept path inherits its parent's history shifted left by one, with u appended as bit 0. Slots beyond the live count are released. `dec_bit` is bit 15 of the history that the best survivor's parent held, which is the decision made 16 steps earlier.
- R7: `cfg_wr` stores a pending limit and threshold. These become active only when step number k*`RECFG_STEPS` completes, and apply from the next step. After reset, M=8 and the threshold is 4095.
- R8: `ready` is high only when idle. If `bm_valid` is sampled high with `ready` at clock edge t, then `step_done` is a one-cycle pulse in the cycle after edge t+K+1, where K is the number of paths kept, and `ready` is low in between. `bm_valid` while `ready` is low is ignored.
- R9: After reset there is one live path in slot 0 with state 0, metric 4095 and an all-zero history. `live_count`=1, `dec_bit`=0, `best_state`=0, `ready`=1 and `step_done`=0.
- R10: `best_state` gives the encoder state of slot 0 after each step, and `live_count` gives the number of kept paths. Both hold until the next step completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Store pending path limit and threshold |
| cfg_max_paths | input | 4 | Requested path limit M |
| cfg_thresh | input | 12 | Requested pruning threshold T |
| bm_valid | input | 1 | Branch metrics present |
| bm_in | input | 32 | Four 8-bit branch metrics, indexed by symbol {sys,par} |
| ready | output | 1 | Unit idle and able to accept a step |
| step_done | output | 1 | One-cycle pulse when a step's results are posted |
| dec_bit | output | 1 | Decoded bit leaving the best survivor's history |
| best_state | output | 3 | Encoder state of the best survivor |
| live_count | output | 4 | Number of live paths |

## Verification
The latency of each step depends on the data, because the ranking phase takes one cycle per kept path. For every step, the bench first computes the expected kept count K from its own list-based model. After the accepting edge it counts falling edges and requires `step_done` on exactly the (K+2)-th, with `ready` low on every falling edge before that. The live count, best state and decoded bit are read on that same falling edge, because they are registered together with the pulse and hold until the next step. Configuration writes are checked by counting steps against the reconfiguration boundary rather than cycles. A `bm_valid` held high with junk metrics during the busy phase must leave every result equal to the model's.

// File: rtl/sova_pkg.sv
package sova_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RANK = 2'd1,
    PH_POST = 2'd2
  } phase_t;

  // Shift-register encoder with 3 memory bits: new bit enters at bit 0.
  function automatic logic [2:0] next_state(input logic [2:0] s, input logic u);
    return {s[1:0], u};
  endfunction

  // Output symbol {systematic, parity}; index into the branch-metric word.
  function automatic logic [1:0] sym_of(input logic [2:0] s, input logic u);
    return {u, u ^ s[2] ^ s[0]};
  endfunction

endpackage

// File: rtl/sova_cand_gen.sv
module sova_cand_gen #(
  parameter int NPATH = 8,
  parameter int MW    = 12,
  parameter int BMW   = 8,
  localparam int NCAND = 2 * NPATH,
  localparam int CW    = MW + 1
) (
  input  logic [NPATH-1:0]           live_vld,
  input  logic [NPATH-1:0][MW-1:0]   live_pm,
  input  logic [NPATH-1:0][2:0]      live_st,
  input  logic [4*BMW-1:0]           bm_flat,
  input  logic [MW-1:0]              thr,
  output logic [NCAND-1:0][CW-1:0]   cand_cm,
  output logic [NCAND-1:0]           cand_ok,
  output logic [CW-1:0]              best_cm
);

  // One adder per candidate: parent metric plus the branch metric of its symbol.
  for (genvar j = 0; j < NCAND; j++) begin : g_cand
    localparam int SRC = j / 2;
    localparam logic UBIT = 1'(j % 2);
    logic [1:0]     sym;
    logic [BMW-1:0] bmv;
    assign sym = sova_pkg::sym_of(live_st[SRC], UBIT);
    assign bmv = bm_flat[sym*BMW +: BMW];
    assign cand_cm[j] = live_vld[SRC] ? ({1'b0, live_pm[SRC]} + CW'(bmv)) : '0;
  end

  always_comb begin
    best_cm = '0;
    for (int j = 0; j < NCAND; j++) begin
      if (live_vld[j/2] && (cand_cm[j] > best_cm)) best_cm = cand_cm[j];
    end
  end

  always_comb begin
    for (int j = 0; j < NCAND; j++) begin
      cand_ok[j] = live_vld[j/2] && ((best_cm - cand_cm[j]) <= {1'b0, thr});
    end
  end

endmodule

// File: rtl/sova_pick.sv
module sova_pick #(
  parameter int NCAND = 16,
  parameter int CW    = 13,
  localparam int CIW  = $clog2(NCAND)
) (
  input  logic [NCAND-1:0][CW-1:0] cm,
  input  logic [NCAND-1:0]         avail,
  output logic                     any,
  output logic [CIW-1:0]           idx
);

  logic [CW-1:0] bv;

  // Linear scan; strict greater-than leaves ties with the lower index.
  always_comb begin
    any = 1'b0;
    idx = '0;
    bv  = '0;
    for (int j = 0; j < NCAND; j++) begin
      if (avail[j] && (!any || (cm[j] > bv))) begin
        any = 1'b1;
        idx = CIW'(j);
        bv  = cm[j];
      end
    end
  end

endmodule

// File: rtl/sova_cfg.sv
module sova_cfg #(
  parameter int NPATH  = 8,
  parameter int MW     = 12,
  parameter int PERIOD = 250000,
  parameter int DEF_M  = 8,
  parameter int DEF_T  = 4095,
  localparam int PCW   = $clog2(NPATH + 1),
  localparam int TW    = $clog2(PERIOD + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [PCW-1:0] cfg_m,
  input  logic [MW-1:0]  cfg_t,
  input  logic           step_tick,
  output logic [PCW-1:0] act_m,
  output logic [MW-1:0]  act_t
);

  logic [PCW-1:0] pend_m;
  logic [MW-1:0]  pend_t;
  logic [TW-1:0]  step_cnt;
  logic           boundary;

  function automatic logic [PCW-1:0] clamp_m(input logic [PCW-1:0] v);
    if (v == '0) return PCW'(1);
    if (int'(v) > NPATH) return PCW'(NPATH);
    return v;
  endfunction

  assign boundary = step_tick && (step_cnt == TW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_m   <= PCW'(DEF_M);
      pend_t   <= MW'(DEF_T);
      act_m    <= PCW'(DEF_M);
      act_t    <= MW'(DEF_T);
      step_cnt <= '0;
    end else begin
      if (cfg_wr) begin
        pend_m <= clamp_m(cfg_m);
        pend_t <= cfg_t;
      end
      if (boundary) begin
        step_cnt <= '0;
        act_m    <= pend_m;
        act_t    <= pend_t;
      end else if (step_tick) begin
        step_cnt <= step_cnt + 1'b1;
      end
    end
  end

  // R4: the active limit is always a usable slot count
  a_r4_limit_range: assert property (@(posedge clk) disable iff (!rst_n)
    (act_m != '0) && (int'(act_m) <= NPATH));

  // R7: active settings change only on a boundary step
  a_r7_swap_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_m) && $stable(act_t));

endmodule

// File: rtl/sova_path_unit.sv
module sova_path_unit #(
  parameter int NPATH       = 8,
  parameter int MW          = 12,
  parameter int BMW         = 8,
  parameter int HIST        = 16,
  parameter int RECFG_STEPS = 250000,
  parameter int DEF_M       = NPATH,
  parameter int DEF_T       = (1 << MW) - 1,
  localparam int PCW   = $clog2(NPATH + 1),
  localparam int SIW   = $clog2(NPATH),
  localparam int NCAND = 2 * NPATH,
  localparam int CIW   = $clog2(NCAND),
  localparam int CW    = MW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [PCW-1:0] cfg_max_paths,
  input  logic [MW-1:0]  cfg_thresh,
  input  logic           bm_valid,
  input  logic [4*BMW-1:0] bm_in,
  output logic           ready,
  output logic           step_done,
  output logic           dec_bit,
  output logic [2:0]     best_state,
  output logic [PCW-1:0] live_count
);
  import sova_pkg::*;

  localparam logic [CW-1:0] FULL = CW'((1 << MW) - 1);

  // live survivor list
  logic [NPATH-1:0]                live_vld;
  logic [NPATH-1:0][MW-1:0]        live_pm;
  logic [NPATH-1:0][2:0]           live_st;
  logic [NPATH-1:0][HIST-1:0]      live_hist;
  // list under construction
  logic [NPATH-1:0][MW-1:0]        new_pm;
  logic [NPATH-1:0][2:0]           new_st;
  logic [NPATH-1:0][HIST-1:0]      new_hist;
  // candidate snapshot
  logic [NCAND-1:0][CW-1:0]        snap_cm;
  logic [NCAND-1:0]                snap_avail;
  logic [CW-1:0]                   snap_best;

  phase_t         phase;
  logic [PCW-1:0] keep_n, rank_cnt, m_used;
  logic [MW-1:0]  t_used;
  logic           out_q;

  // combinational candidate stage
  logic [NCAND-1:0][CW-1:0] cand_cm;
  logic [NCAND-1:0]         cand_ok;
  logic [CW-1:0]            best_cm;
  logic [PCW-1:0]           act_m;
  logic [MW-1:0]            act_t;
  logic [CIW:0]             elig_cnt;
  logic [PCW-1:0]           keep_calc;

  // named events for checks
  logic           accept;
  logic           pick_any;
  logic [CIW-1:0] pick_idx;
  logic [CW-1:0]  pick_cm;
  logic [SIW-1:0] pick_src;
  logic           pick_u;
  logic [SIW-1:0] rank_slot;
  logic           last_pick;

  assign ready     = (phase == PH_IDLE);
  assign accept    = ready && bm_valid;
  assign pick_cm   = snap_cm[pick_idx];
  assign pick_src  = pick_idx[CIW-1:1];
  assign pick_u    = pick_idx[0];
  assign rank_slot = rank_cnt[SIW-1:0];
  assign last_pick = (phase == PH_RANK) && ((rank_cnt + 1'b1) == keep_n);

  function automatic logic [MW-1:0] renorm(input logic [CW-1:0] best,
                                           input logic [CW-1:0] cm);
    return MW'(FULL - (best - cm));
  endfunction

  sova_cfg #(
    .NPATH(NPATH), .MW(MW), .PERIOD(RECFG_STEPS), .DEF_M(DEF_M), .DEF_T(DEF_T)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_m(cfg_max_paths),
    .cfg_t(cfg_thresh), .step_tick(phase == PH_POST),
    .act_m(act_m), .act_t(act_t)
  );

  sova_cand_gen #(.NPATH(NPATH), .MW(MW), .BMW(BMW)) u_cand (
    .live_vld(live_vld), .live_pm(live_pm), .live_st(live_st),
    .bm_flat(bm_in), .thr(act_t),
    .cand_cm(cand_cm), .cand_ok(cand_ok), .best_cm(best_cm)
  );

  sova_pick #(.NCAND(NCAND), .CW(CW)) u_pick (
    .cm(snap_cm), .avail(snap_avail), .any(pick_any), .idx(pick_idx)
  );

  always_comb begin
    elig_cnt = '0;
    for (int j = 0; j < NCAND; j++) elig_cnt = elig_cnt + (CIW+1)'(cand_ok[j]);
    if (int'(elig_cnt) > int'(act_m)) keep_calc = act_m;
    else                              keep_calc = PCW'(elig_cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      live_vld   <= NPATH'(1);
      live_pm    <= '0;
      live_pm[0] <= FULL[MW-1:0];
      live_st    <= '0;
      live_hist  <= '0;
      new_pm     <= '0;
      new_st     <= '0;
      new_hist   <= '0;
      snap_cm    <= '0;
      snap_avail <= '0;
      snap_best  <= '0;
      keep_n     <= '0;
      rank_cnt   <= '0;
      m_used     <= '0;
      t_used     <= '0;
      out_q      <= 1'b0;
      step_done  <= 1'b0;
      dec_bit    <= 1'b0;
      best_state <= '0;
      live_count <= PCW'(1);
    end else begin
      step_done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (bm_valid) begin
            snap_cm    <= cand_cm;
            snap_avail <= cand_ok;
            snap_best  <= best_cm;
            keep_n     <= keep_calc;
            m_used     <= act_m;
            t_used     <= act_t;
            rank_cnt   <= '0;
            phase      <= PH_RANK;
          end
        end
        PH_RANK: begin
          new_pm[rank_slot]   <= renorm(snap_best, pick_cm);
          new_st[rank_slot]   <= next_state(live_st[pick_src], pick_u);
          new_hist[rank_slot] <= {live_hist[pick_src][HIST-2:0], pick_u};
          if (rank_cnt == '0) out_q <= live_hist[pick_src][HIST-1];
          snap_avail[pick_idx] <= 1'b0;
          rank_cnt <= rank_cnt + 1'b1;
          if (last_pick) phase <= PH_POST;
        end
        PH_POST: begin
          for (int i = 0; i < NPATH; i++) begin
            if (i < int'(keep_n)) begin
              live_vld[i]  <= 1'b1;
              live_pm[i]   <= new_pm[i];
              live_st[i]   <= new_st[i];
              live_hist[i] <= new_hist[i];
            end else begin
              live_vld[i]  <= 1'b0;
              live_pm[i]   <= '0;
              live_st[i]   <= '0;
              live_hist[i] <= '0;
            end
          end
          live_count <= keep_n;
          dec_bit    <= out_q;
          best_state <= new_st[0];
          step_done  <= 1'b1;
          phase      <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: every ranked candidate is within the threshold of the best
  a_r2_pick_within_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RANK) |-> pick_any && ((snap_best - pick_cm) <= {1'b0, t_used}));

  // R3: ranking emits metrics in non-increasing order
  a_r3_descending: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RANK) && $past(phase == PH_RANK)) |-> (pick_cm <= $past(pick_cm)));

  // R4: posted live count is between 1 and the limit used for that step
  a_r4_live_cap: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (live_count != '0) && (live_count <= m_used));

  // R5: the best survivor sits at full scale after every step
  a_r5_best_full: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (live_pm[0] == FULL[MW-1:0]));

  // R6: released slots match the live count
  a_r6_released: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> ($countones(live_vld) == int'(live_count)));

  // R8: one-cycle done pulse, posted while ready
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> ready ##1 !step_done);

  // R8: a step in progress cannot be restarted
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RANK) |=> (phase != PH_IDLE));

endmodule

// File: tb/sova_path_unit_test.sv
module sova_path_unit_test;
  localparam int PER = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_max_paths = '0;
  logic [11:0] cfg_thresh = '0;
  logic        bm_valid = 1'b0;
  logic [31:0] bm_in = '0;
  logic        ready, step_done, dec_bit;
  logic [2:0]  best_state;
  logic [3:0]  live_count;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  sova_path_unit #(.RECFG_STEPS(PER)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_max_paths(cfg_max_paths),
    .cfg_thresh(cfg_thresh), .bm_valid(bm_valid), .bm_in(bm_in),
    .ready(ready), .step_done(step_done), .dec_bit(dec_bit),
    .best_state(best_state), .live_count(live_count)
  );

  // ---------------- reference model (list with stable insertion sort)
  int m_pm[8], m_st[8], m_hist[8], m_n;
  int m_act_m, m_act_t, m_pend_m, m_pend_t, m_cnt;
  int e_keep, e_dec, e_best;

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_pm[i] = 0; m_st[i] = 0; m_hist[i] = 0; end
    m_pm[0] = 4095; m_n = 1;
    m_act_m = 8; m_act_t = 4095; m_pend_m = 8; m_pend_t = 4095; m_cnt = 0;
  endtask

  task automatic model_step(input int bm[4]);
    int cm[16]; int ord[16]; int nord; int best; int pos;
    int npm[8], nst[8], nh[8];
    best = -1;
    for (int j = 0; j < 2*m_n; j++) begin
      int s, u, sym;
      s = j / 2; u = j % 2;
      sym = u*2 + (u ^ ((m_st[s] >> 2) & 1) ^ (m_st[s] & 1));
      cm[j] = m_pm[s] + bm[sym];
      if (cm[j] > best) best = cm[j];
    end
    nord = 0;
    for (int j = 0; j < 2*m_n; j++) begin
      if (best - cm[j] <= m_act_t) begin
        pos = nord;
        while (pos > 0 && cm[ord[pos-1]] < cm[j]) begin ord[pos] = ord[pos-1]; pos--; end
        ord[pos] = j; nord++;
      end
    end
    e_keep = (nord < m_act_m) ? nord : m_act_m;
    for (int k = 0; k < e_keep; k++) begin
      int j, s, u;
      j = ord[k]; s = j / 2; u = j % 2;
      npm[k] = 4095 - (best - cm[j]);
      nst[k] = ((m_st[s] << 1) | u) & 7;
      nh[k]  = ((m_hist[s] << 1) | u) & 16'hFFFF;
      if (k == 0) e_dec = (m_hist[s] >> 15) & 1;
    end
    for (int k = 0; k < 8; k++) begin
      m_pm[k] = (k < e_keep) ? npm[k] : 0;
      m_st[k] = (k < e_keep) ? nst[k] : 0;
      m_hist[k] = (k < e_keep) ? nh[k] : 0;
    end
    m_n = e_keep; e_best = nst[0];
    if (m_cnt == PER-1) begin m_cnt = 0; m_act_m = m_pend_m; m_act_t = m_pend_t; end
    else m_cnt++;
  endtask

  // ---------------- helpers
  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bm_valid = 1'b0; cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic cfg_write(input int mv, input int tv);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_max_paths = 4'(mv); cfg_thresh = 12'(tv);
    @(negedge clk);
    cfg_wr = 1'b0;
    m_pend_m = (mv == 0) ? 1 : ((mv > 8) ? 8 : mv);
    m_pend_t = tv;
  endtask

  // one trellis step; noisy keeps bm_valid high with junk while busy (R8)
  task automatic do_step(input int bm[4], input bit noisy);
    int k; bit busy_bad;
    model_step(bm);
    for (int i = 0; i < 4; i++) bm_in[i*8 +: 8] = 8'(bm[i]);
    bm_valid = 1'b1;
    @(negedge clk);
    if (noisy) bm_in = 32'hFF00_FF00; else bm_valid = 1'b0;
    k = 1; busy_bad = 1'b0;
    while (!step_done && k < 40) begin
      if (ready) busy_bad = 1'b1;
      @(negedge clk); k++;
    end
    bm_valid = 1'b0;
    chk("R8 done latency", k, e_keep + 2);
    chk("R8 ready low while busy", int'(busy_bad), 0);
    chk("R4 live count", int'(live_count), e_keep);
    chk("R10 best state", int'(best_state), e_best);
    chk("R6 decoded bit", int'(dec_bit), e_dec);
  endtask

  task automatic finish_period(input int bm[4]);
    do do_step(bm, 1'b0); while (m_cnt != 0);
  endtask

  // ---------------- scenarios
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R9 ready", int'(ready), 1);
    chk("R9 done low", int'(step_done), 0);
    chk("R9 live count", int'(live_count), 1);
    chk("R9 dec_bit", int'(dec_bit), 0);
    chk("R9 best_state", int'(best_state), 0);
  endtask

  task automatic t_growth();
    int eq[4] = '{10, 10, 10, 10};
    int exp_live[4] = '{2, 4, 8, 8};
    for (int s = 0; s < 4; s++) begin
      do_step(eq, 1'b0);
      chk("R4 growth capped at 8 (R1 both extensions)", int'(live_count), exp_live[s]);
    end
  endtask

  task automatic t_reconfig();
    int eq[4] = '{5, 5, 5, 5};
    cfg_write(2, 4095);
    for (int s = 0; s < 4; s++) begin
      do_step(eq, 1'b0);
      chk("R7 old limit until boundary", int'(live_count), 8);
    end
    do_step(eq, 1'b0);
    chk("R7 new limit after boundary", int'(live_count), 2);
  endtask

  task automatic t_clamp();
    int eq[4] = '{7, 7, 7, 7};
    cfg_write(0, 4095);
    finish_period(eq);
    do_step(eq, 1'b0);
    chk("R4 limit 0 acts as 1", int'(live_count), 1);
    cfg_write(15, 4095);
    finish_period(eq);
    do_step(eq, 1'b0);
    do_step(eq, 1'b0);
    do_step(eq, 1'b0);
    do_step(eq, 1'b0);
    chk("R4 limit 15 acts as 8", int'(live_count), 8);
  endtask

  task automatic t_tie();
    int eq[4] = '{3, 3, 3, 3};
    int fav[4] = '{0, 0, 0, 50};
    cfg_write(1, 4095);
    finish_period(eq);
    for (int s = 0; s < 3; s++) do_step(eq, 1'b0);
    chk("R3 tie keeps lower index u=0", int'(best_state), 0);
    do_step(fav, 1'b0);
    chk("R3 larger metric wins (R1 symbol 3)", int'(best_state), 1);
  endtask

  task automatic t_thresh();
    int eq[4] = '{9, 9, 9, 9};
    int one[4] = '{60, 0, 0, 0};
    cfg_write(8, 0);
    finish_period(eq);
    do_step(eq, 1'b0);
    chk("R2 threshold 0 keeps exact ties", int'(live_count), 2);
    do_step(eq, 1'b0);
    chk("R2 threshold 0 keeps exact ties", int'(live_count), 4);
    do_step(one, 1'b0);
    chk("R2 only symbol 0 extensions survive", int'(live_count), e_keep);
    cfg_write(8, 30);
    finish_period(one);
  endtask

  task automatic t_decode();
    logic [7:0] lfsr = 8'hA5;
    int ubits[80]; int st = 0;
    do_reset();
    for (int n = 1; n <= 70; n++) begin
      int u, sym; int bm[4];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      u = int'(lfsr[0]);
      ubits[n] = u;
      sym = u*2 + (u ^ ((st >> 2) & 1) ^ (st & 1));
      for (int i = 0; i < 4; i++) bm[i] = 40 * (2 - $countones(2'(i ^ sym)));
      st = ((st << 1) | u) & 7;
      do_step(bm, (n % 3) == 0);
      if (n >= 17) chk("R6 R5 decoded bit equals input 16 steps back",
                       int'(dec_bit), ubits[n-16]);
      if (n >= 3) chk("R1 best state tracks encoder", int'(best_state), st);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    t_reset();
    t_growth();
    t_reconfig();
    t_clamp();
    t_tie();
    t_thresh();
    t_decode();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule